// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block carries out indirect reads and writes into a PHY's internal control-register space. The PHY exposes only a narrow port: an outgoing word that holds a 16-bit data-in value and four strobes, and a return word that holds an acknowledge and a 16-bit data-out value. A host hands the block one request at a time: an address, write data and a direction. The block breaks the request into a fixed series of strobed steps and reports completion, a timeout error with its location, and the read data.

Each step is a four-phase handshake. The block drives the value with one strobe and waits for the acknowledge to rise. It then drops the strobe, keeps the value, and waits for the acknowledge to fall. A bounded number of polling intervals limits each wait. A write is three steps: capture the address, capture the data, then commit. A read is two steps: capture the address, then read. The acknowledge may come from another clock domain, so it is synchronized before use.

Top module: `phy_cr_master`

## Requirements
- R1: The port word `cr_port_o` carries the data-in value at bits [DATA_W+1:2]. The capture-address strobe is bit 0, capture-data is bit 1, read is bit DATA_W+2 and write is bit DATA_W+3. With default widths these are bits 18 and 19.
- R2: In the return word `cr_ret_i`, bit 0 is the acknowledge and bits [DATA_W:1] are data-out.
- R3: During a handshake at most one strobe is set. The strobe and value stay in place until the synchronized acknowledge is seen high. The strobe then clears with the same value held until the acknowledge is seen low.
- R4: Before every strobe rises, the same value is driven with no strobe for at least one cycle.
- R5: A write issues three handshakes in this order: address with capture-address, write data with capture-data, write data with write.
- R6: A read issues two handshakes: address with capture-address, then address with read. `rdata_o` takes data-out on the cycle the acknowledge is seen high during the read step.
- R7: Each wait phase restarts its own bound of POLL_CYCLES*TIMEOUT_POLLS cycles. An acknowledge edge that reaches the raw input no later than two cycles before the bound ends still counts. Otherwise the strobe clears, the operation ends with `err_o` set, and no further strobe is issued.
- R8: On a timeout, `err_step_o` names the failing step: 0 address capture, 1 data capture, 2 write commit, 3 read. `err_phase_o` is 0 when the block was waiting for the acknowledge to rise and 1 when it was waiting for it to fall. Both are 0 on success.
- R9: A request is taken only while `busy_o` is low, and a request while busy has no effect. `busy_o` is high from the cycle after acceptance until completion. `done_o` is a one-cycle pulse with `busy_o` low, and `err_o` is valid with it. No strobe is set while idle.
- R10: The acknowledge passes through a two-flop synchronizer. An active strobe clears on the third clock edge after the raw acknowledge rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken while idle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | DATA_W | Register address |
| wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error, valid with done_o |
| err_step_o | output | 2 | Failing step code |
| err_phase_o | output | 1 | Failing wait phase |
| rdata_o | output | DATA_W | Data from the last read |
| cr_port_o | output | DATA_W+4 | Port word: data-in and strobes |
| cr_ret_i | input | DATA_W+1 | Return word: acknowledge and data-out |

## Verification
The bench builds the block with POLL_CYCLES=2 and TIMEOUT_POLLS=6, so each wait is bounded at 12 cycles. At that size a responder delay of 9 cycles just succeeds and 10 just times out, in both the rise and the fall phase. A timed-out strobe lasting exactly 13 cycles can be measured directly. A two-cycle poll interval also exercises the prescaler path, which the default of 1 bypasses.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  // strobe code doubles as its bit index in the one-hot strobe vector
  typedef enum logic [1:0] {
    STB_CAP_ADDR = 2'd0,
    STB_CAP_DATA = 2'd1,
    STB_READ     = 2'd2,
    STB_WRITE    = 2'd3
  } stb_e;

  typedef enum logic [1:0] {
    STEP_ADDR   = 2'd0,
    STEP_DATA   = 2'd1,
    STEP_COMMIT = 2'd2,
    STEP_READ   = 2'd3
  } step_e;
endpackage

// File: rtl/phy_cr_sync.sv
module phy_cr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/phy_cr_timer.sv
module phy_cr_timer #(
  parameter int unsigned POLL_CYCLES   = 1,
  parameter int unsigned TIMEOUT_POLLS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned PRE_W = $clog2(POLL_CYCLES + 1);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(POLL_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_POLLS);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cnt_q != CNT_LAST) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/phy_cr_hs.sv
module phy_cr_hs
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned POLL_CYCLES   = 1,
  parameter int unsigned TIMEOUT_POLLS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  stb_e              stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic [DATA_W+3:0] port_o,
  output logic              ack_hi_o,
  output logic              done_o,
  output logic              tmo_o,
  output logic              tmo_phase_o
);
  typedef enum logic [1:0] {HS_IDLE, HS_SETUP, HS_ASSERT, HS_RELEASE} hs_e;

  hs_e               state_q;
  stb_e              stb_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, tmo_q, phase_q;
  logic              load, expired;
  logic [3:0]        stb_vec;

  assign load = (state_q == HS_SETUP) || (state_q == HS_ASSERT && ack_i);

  phy_cr_timer #(
    .POLL_CYCLES  (POLL_CYCLES),
    .TIMEOUT_POLLS(TIMEOUT_POLLS)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      stb_q   <= STB_CAP_ADDR;
      data_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        HS_IDLE: if (start_i) begin
          data_q  <= data_i;
          stb_q   <= stb_i;
          state_q <= HS_SETUP;
        end
        HS_SETUP: state_q <= HS_ASSERT;
        HS_ASSERT: begin
          if (ack_i) begin
            state_q <= HS_RELEASE;
          end else if (expired) begin
            state_q <= HS_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
            phase_q <= 1'b0;
          end
        end
        HS_RELEASE: begin
          if (!ack_i) begin
            state_q <= HS_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b0;
            phase_q <= 1'b0;
          end else if (expired) begin
            state_q <= HS_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
            phase_q <= 1'b1;
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign stb_vec     = (state_q == HS_ASSERT) ? (4'b0001 << stb_q) : 4'b0000;
  assign port_o      = {stb_vec[3], stb_vec[2], data_q, stb_vec[1], stb_vec[0]};
  assign ack_hi_o    = (state_q == HS_ASSERT) && ack_i;
  assign done_o      = done_q;
  assign tmo_o       = tmo_q;
  assign tmo_phase_o = phase_q;
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned POLL_CYCLES   = 1,
  parameter int unsigned TIMEOUT_POLLS = 100,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_step_o,
  output logic              err_phase_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W+3:0] cr_port_o,
  input  logic [DATA_W:0]   cr_ret_i
);
  typedef enum logic [2:0] {T_IDLE, T_ADDR, T_DATA, T_COMMIT, T_READ} seq_e;

  seq_e              state_q;
  logic              we_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic              done_q, err_q, phase_q;
  step_e             step_q;

  logic              ack_sync;
  logic              accept;
  logic              hs_start, hs_ack_hi, hs_done, hs_tmo, hs_phase;
  stb_e              hs_stb;
  logic [DATA_W-1:0] hs_data;
  step_e             cur_step;

  phy_cr_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cr_ret_i[0]),
    .q_o   (ack_sync)
  );

  phy_cr_hs #(
    .DATA_W       (DATA_W),
    .POLL_CYCLES  (POLL_CYCLES),
    .TIMEOUT_POLLS(TIMEOUT_POLLS)
  ) i_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (hs_start),
    .stb_i      (hs_stb),
    .data_i     (hs_data),
    .ack_i      (ack_sync),
    .port_o     (cr_port_o),
    .ack_hi_o   (hs_ack_hi),
    .done_o     (hs_done),
    .tmo_o      (hs_tmo),
    .tmo_phase_o(hs_phase)
  );

  assign accept = (state_q == T_IDLE) && req_i;

  always_comb begin
    hs_start = 1'b0;
    hs_stb   = STB_CAP_ADDR;
    hs_data  = addr_i;
    if (accept) begin
      hs_start = 1'b1;
    end else if (hs_done && !hs_tmo) begin
      unique case (state_q)
        T_ADDR: begin
          hs_start = 1'b1;
          hs_stb   = we_q ? STB_CAP_DATA : STB_READ;
          hs_data  = we_q ? wdata_q : addr_q;
        end
        T_DATA: begin
          hs_start = 1'b1;
          hs_stb   = STB_WRITE;
          hs_data  = wdata_q;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      T_DATA:   cur_step = STEP_DATA;
      T_COMMIT: cur_step = STEP_COMMIT;
      T_READ:   cur_step = STEP_READ;
      default:  cur_step = STEP_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= T_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      phase_q <= 1'b0;
      step_q  <= STEP_ADDR;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        state_q <= T_ADDR;
        we_q    <= write_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (hs_done) begin
        if (hs_tmo) begin
          state_q <= T_IDLE;
          done_q  <= 1'b1;
          err_q   <= 1'b1;
          step_q  <= cur_step;
          phase_q <= hs_phase;
        end else begin
          unique case (state_q)
            T_ADDR: state_q <= we_q ? T_DATA : T_READ;
            T_DATA: state_q <= T_COMMIT;
            default: begin
              state_q <= T_IDLE;
              done_q  <= 1'b1;
              step_q  <= STEP_ADDR;
              phase_q <= 1'b0;
            end
          endcase
        end
      end
      if (hs_ack_hi && state_q == T_READ) rdata_q <= cr_ret_i[DATA_W:1];
    end
  end

  assign busy_o      = (state_q != T_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_step_o  = step_q;
  assign err_phase_o = phase_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W+3:0] port,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              ack_s
);
  logic [3:0]        stb;
  logic [DATA_W-1:0] dat;
  logic              any;

  assign stb = {port[DATA_W+3], port[DATA_W+2], port[1], port[0]};
  assign dat = port[DATA_W+1:2];
  assign any = |stb;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb)); // R3
  AST_SETUP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any) |-> (dat == $past(dat))); // R4
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(any) |-> (dat == $past(dat))); // R3
  AST_STB_TILL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(any) && !$past(ack_s)) |=> (done && err)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !busy); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !any); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |-> done); // R9
endmodule

bind phy_cr_master phy_cr_master_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .port  (cr_port_o),
  .busy  (busy_o),
  .done  (done_o),
  .err   (err_o),
  .ack_s (ack_sync)
);

// File: tb/test_phy_cr_master.sv
module test_phy_cr_master;
  localparam int DW = 16;
  localparam int PC = 2;
  localparam int TP = 6;
  localparam int LIM = PC * TP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req = 1'b0, wr = 1'b0;
  logic [DW-1:0] addr = '0, wdata = '0;
  logic          busy, done, err, phase;
  logic [1:0]    step;
  logic [DW-1:0] rdata;
  logic [DW+3:0] port;
  logic          ack = 1'b0;
  logic [DW-1:0] dout = '0;
  logic [DW:0]   ret;

  assign ret = {dout, ack};

  phy_cr_master #(
    .DATA_W(DW), .POLL_CYCLES(PC), .TIMEOUT_POLLS(TP), .SYNC_STAGES(2)
  ) i_phy_cr_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .write_i(wr), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .err_step_o(step), .err_phase_o(phase), .rdata_o(rdata),
    .cr_port_o(port), .cr_ret_i(ret)
  );

  wire [3:0]    stb  = {port[DW+3], port[DW+2], port[1], port[0]};
  wire [DW-1:0] pdat = port[DW+1:2];

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // PHY responder
  int            rise_dly[4];
  int            fall_dly = 0;
  int            cnt = 0;
  int            log_n = 0;
  logic [DW+3:0] log_raw[64];
  logic [DW-1:0] r_addr = '0, r_dat = '0;
  logic [DW-1:0] phy_mem[16];

  function automatic int stb_idx(input logic [3:0] s);
    if (s[0]) return 0;
    if (s[1]) return 1;
    if (s[2]) return 2;
    return 3;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) phy_mem[i] = 16'hA000 + 16'(i);
    forever @(posedge clk) begin
      if (|stb && !ack) begin
        if (cnt >= rise_dly[stb_idx(stb)]) begin
          ack <= 1'b1;
          cnt <= 0;
          log_raw[log_n % 64] <= port;
          log_n <= log_n + 1;
          if (stb[0]) r_addr <= pdat;
          if (stb[1]) r_dat <= pdat;
          if (stb[3]) phy_mem[r_addr[3:0]] <= r_dat;
          if (stb[2]) dout <= phy_mem[r_addr[3:0]];
        end else cnt <= cnt + 1;
      end else if (!(|stb) && ack) begin
        if (cnt >= fall_dly) begin
          ack <= 1'b0;
          cnt <= 0;
        end else cnt <= cnt + 1;
      end else cnt <= 0;
    end
  end

  // negedge monitor
  int cyc = 0, run = 0, last_run = 0, rises = 0, ack_cyc = 0, last_lat = 0, setup_bad = 0;
  bit prev_any = 0, prev_ack = 0;
  logic [DW-1:0] prev_dat = '0;
  initial forever @(negedge clk) begin
    cyc++;
    if (|stb) begin
      if (!prev_any) begin
        rises++;
        if (pdat != prev_dat) setup_bad++;
      end
      run++;
    end else if (prev_any) begin
      last_run = run;
      run = 0;
      last_lat = cyc - ack_cyc;
    end
    if (ack && !prev_ack) ack_cyc = cyc;
    prev_any = |stb;
    prev_ack = ack;
    prev_dat = pdat;
  end

  logic [DW-1:0] model[16];

  task automatic do_op(input bit we, input logic [DW-1:0] a, input logic [DW-1:0] d,
                       input bit poke, output bit e, output logic [1:0] st,
                       output bit ph, output logic [DW-1:0] rd, output int base);
    int n;
    base = log_n;
    @(negedge clk);
    req = 1'b1; wr = we; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req = 1'b1; wr = 1'b1; addr = 16'h000F; wdata = 16'hDEAD;
      @(negedge clk);
      req = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, "R9 done seen", n, 0);
    chk(busy === 1'b0, "R9 idle with done", busy, 0);
    e = err; st = step; ph = phase; rd = rdata;
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", done, 0);
    while (ack) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [DW+3:0] pw(input int s, input logic [DW-1:0] v);
    logic [DW+3:0] w;
    w = {2'b00, v, 2'b00};
    w[s == 2 ? DW+2 : s == 3 ? DW+3 : s] = 1'b1;
    return w;
  endfunction

  task automatic set_dly(input int r);
    for (int i = 0; i < 4; i++) rise_dly[i] = r;
  endtask

  initial begin
    bit e, ph;
    logic [1:0] st;
    logic [DW-1:0] rd;
    int base, r0;
    void'($urandom(32'h5EED));
    set_dly(0);
    for (int i = 0; i < 16; i++) model[i] = 16'hA000 + 16'(i);
    repeat (3) @(negedge clk);
    chk(port === '0, "R9 reset port quiet", port, 0);
    chk(busy === 1'b0 && done === 1'b0, "R9 reset idle", {busy, done}, 0);
    chk(rdata === '0, "R6 reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed write: sequence and field layout
    do_op(1, 16'h0003, 16'h1234, 0, e, st, ph, rd, base);
    model[3] = 16'h1234;
    chk(e == 0 && st == 0 && ph == 0, "R8 clean done", {e, st, ph}, 0);
    chk(log_n - base == 3, "R5 three steps", log_n - base, 3);
    chk(log_raw[base % 64] === pw(0, 16'h0003), "R1 R5 cap addr word", log_raw[base % 64], pw(0, 16'h0003));
    chk(log_raw[(base + 1) % 64] === pw(1, 16'h1234), "R1 R5 cap data word", log_raw[(base + 1) % 64], pw(1, 16'h1234));
    chk(log_raw[(base + 2) % 64] === pw(3, 16'h1234), "R1 R5 write word", log_raw[(base + 2) % 64], pw(3, 16'h1234));
    chk(last_lat == 3, "R10 strobe clears 3 edges after ack", last_lat, 3);
    chk(last_run == 4, "R3 strobe held until ack", last_run, 4);

    // directed read
    do_op(0, 16'h0003, 16'h0, 0, e, st, ph, rd, base);
    chk(log_n - base == 2, "R6 two steps", log_n - base, 2);
    chk(log_raw[(base + 1) % 64] === pw(2, 16'h0003), "R1 R6 read word", log_raw[(base + 1) % 64], pw(2, 16'h0003));
    chk(rd === 16'h1234 && e == 0, "R2 R6 read data", rd, 16'h1234);

    // rise boundary
    rise_dly[0] = LIM - 3;
    do_op(0, 16'h0007, 16'h0, 0, e, st, ph, rd, base);
    chk(e == 0 && rd === model[7], "R7 rise bound edge succeeds", {e, rd}, {1'b0, model[7]});
    r0 = rises;
    rise_dly[0] = LIM - 2;
    do_op(1, 16'h0008, 16'h5555, 0, e, st, ph, rd, base);
    chk(e == 1 && st == 0 && ph == 0, "R7 R8 rise timeout addr", {e, st, ph}, 3'b100);
    chk(last_run == LIM + 1, "R7 strobe length at timeout", last_run, LIM + 1);
    chk(rises - r0 == 1, "R7 no strobe after timeout", rises - r0, 1);
    set_dly(0);

    // data-capture step timeout
    rise_dly[1] = 20;
    do_op(1, 16'h0005, 16'hBEEF, 0, e, st, ph, rd, base);
    chk(e == 1 && st == 1 && ph == 0, "R8 timeout data step", {e, st, ph}, 3'b101);
    set_dly(0);
    // commit step timeout
    rise_dly[3] = 20;
    do_op(1, 16'h0006, 16'hCAFE, 0, e, st, ph, rd, base);
    chk(e == 1 && st == 2 && ph == 0, "R8 timeout commit step", {e, st, ph}, 3'b110);
    set_dly(0);
    // read step timeout
    rise_dly[2] = 20;
    do_op(0, 16'h0006, 16'h0, 0, e, st, ph, rd, base);
    chk(e == 1 && st == 3 && ph == 0, "R8 timeout read step", {e, st, ph}, 3'b111);
    set_dly(0);

    // fall boundary
    fall_dly = LIM - 3;
    do_op(0, 16'h0009, 16'h0, 0, e, st, ph, rd, base);
    chk(e == 0 && rd === model[9], "R7 fall bound edge succeeds", {e, rd}, {1'b0, model[9]});
    r0 = rises;
    fall_dly = LIM - 2;
    do_op(1, 16'h000A, 16'h7777, 0, e, st, ph, rd, base);
    chk(e == 1 && st == 0 && ph == 1, "R7 R8 fall timeout", {e, st, ph}, 3'b001);
    chk(rises - r0 == 1, "R7 stop after fall timeout", rises - r0, 1);
    fall_dly = 0;

    // failed writes left registers unchanged
    do_op(0, 16'h0005, 16'h0, 0, e, st, ph, rd, base);
    chk(rd === model[5], "R7 addr 5 untouched", rd, model[5]);
    do_op(0, 16'h0006, 16'h0, 0, e, st, ph, rd, base);
    chk(rd === model[6], "R7 addr 6 untouched", rd, model[6]);

    // request while busy is ignored
    do_op(1, 16'h0002, 16'h4242, 1, e, st, ph, rd, base);
    model[2] = 16'h4242;
    chk(log_n - base == 3, "R9 busy request ignored", log_n - base, 3);
    do_op(0, 16'h000F, 16'h0, 0, e, st, ph, rd, base);
    chk(rd === model[15], "R9 poke had no effect", rd, model[15]);

    // random traffic
    for (int k = 0; k < 40; k++) begin
      bit we;
      logic [DW-1:0] a, d;
      we = 1'($urandom_range(0, 1));
      a = 16'($urandom_range(0, 65535));
      d = 16'($urandom_range(0, 65535));
      for (int i = 0; i < 4; i++) rise_dly[i] = $urandom_range(0, 5);
      fall_dly = $urandom_range(0, 5);
      do_op(we, a, d, 0, e, st, ph, rd, base);
      chk(e == 0, "R5 R6 random op clean", e, 0);
      if (we) model[a[3:0]] = d;
      else chk(rd === model[a[3:0]], "R6 random read data", rd, model[a[3:0]]);
      chk(log_n - base == (we ? 3 : 2), "R5 R6 random step count", log_n - base, we ? 3 : 2);
    end
    chk(setup_bad == 0, "R4 setup cycle before strobe", setup_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule